// File: doc/BRIEF.md
# Five-Stage In-Order Integer Pipeline

This block is a compact in-order processor core for a seven-instruction subset of a 32-bit load/store instruction set: add, sub, ori, lw, sw, beq and j. Instructions move through five steps in sequence: fetch, which also forms the next sequential address; decode together with register read; execute; data memory access; and register write-back. The core holds the decoder, the ALU, a 32-entry register file and the four pipeline registers between the stages.

The core has two memory ports. The fetch port presents an address and takes back the instruction word in the same cycle. The data port presents an address, store data and a write strobe, and takes back load data in the same cycle. Because fetch and data access use separate ports, they never compete. The core has no forwarding paths. When an instruction needs a result that is still in flight, decode holds and sends bubbles into execute. A branch or jump is resolved in execute. When it redirects, the two younger instructions are discarded.

Top module: `pipe5_core`

## Requirements
- R1: While reset is high, the fetch address equals the reset address (0 by default) and the data write strobe stays low.
- R2: The decoder uses these encodings. Opcode 000000 is register-register, with function 100000 for add and 100010 for sub; the result goes to the rd field (bits 15:11). Opcode 001101 is ori, 100011 is lw, 101011 is sw, 000100 is beq and 000010 is j. The destination of ori and lw is the rt field (bits 20:16), and rs is bits 25:21. Any other encoding writes neither a register nor memory.
- R3: The 16-bit immediate of ori is zero-extended. The offsets of lw and sw are sign-extended and added to rs.
- R4: An instruction that reads a register written by either of the two instructions just ahead of it gets the new value, because decode stalls.
- R5: A register loaded by lw and read by the very next instruction delivers the loaded word.
- R6: A register written in write-back is returned to a decode read of that register in the same cycle, with no stall.
- R7: A beq whose operands are equal continues at PC+4 plus the sign-extended offset shifted left by 2, and the two instructions fetched after it have no effect. A beq whose operands differ falls through.
- R8: A j continues at the upper 4 bits of PC+4 joined with the 26-bit index shifted left by 2, and the two instructions fetched after it have no effect.
- R9: Register 0 reads as zero, and writes to it are dropped.
- R10: Data writes leave the core in program order, one for each executed sw and none for a discarded instruction. The final data memory matches an instruction-level model.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| imem_addr | output | 32 | Fetch byte address |
| imem_rdata | input | 32 | Instruction word at imem_addr |
| dmem_addr | output | 32 | Data byte address |
| dmem_wdata | output | 32 | Store data |
| dmem_we | output | 1 | Store strobe |
| dmem_rdata | input | 32 | Load data at dmem_addr |

## Verification
The bench builds the core with its defaults: a 32-bit word, 32 registers, a reset address of 0, and write-back shared with decode. With sharing enabled, a dependency three instructions apart runs without a stall. The program is laid out so that this spacing, back-to-back dependencies, a load followed at once by its use, a taken and a fall-through branch, and a jump over live code all occur. An instruction-level model predicts every store, and the bench checks each one as it leaves the core.

// File: rtl/pipe5_pkg.sv
`timescale 1ns/1ps
package pipe5_pkg;
   localparam logic [5:0] OP_RTYPE = 6'b000000;
   localparam logic [5:0] OP_ORI   = 6'b001101;
   localparam logic [5:0] OP_LW    = 6'b100011;
   localparam logic [5:0] OP_SW    = 6'b101011;
   localparam logic [5:0] OP_BEQ   = 6'b000100;
   localparam logic [5:0] OP_J     = 6'b000010;
   localparam logic [5:0] FN_ADD   = 6'b100000;
   localparam logic [5:0] FN_SUB   = 6'b100010;

   typedef enum logic [1:0] {
      ALU_ADD = 2'b00,
      ALU_SUB = 2'b01,
      ALU_OR  = 2'b10
   } alu_op_e;

   typedef struct packed {
      logic    legal;
      logic    reg_write;
      logic    mem_to_reg;
      logic    mem_write;
      logic    alu_src;
      logic    reg_dst;
      logic    branch;
      logic    jump;
      logic    sign_ext;
      logic    reads_rs;
      logic    reads_rt;
      alu_op_e alu_op;
   } ctrl_t;
endpackage

// File: rtl/pipe5_decode.sv
`timescale 1ns/1ps
module pipe5_decode
   import pipe5_pkg::*;
(
   input  logic [5:0] opcode,
   input  logic [5:0] funct,
   output ctrl_t      ctrl
);
   always_comb begin
      ctrl        = '0;
      ctrl.alu_op = ALU_ADD;
      case (opcode)
         OP_RTYPE: begin
            if (funct == FN_ADD || funct == FN_SUB) begin
               ctrl.legal     = 1'b1;
               ctrl.reg_write = 1'b1;
               ctrl.reg_dst   = 1'b1;
               ctrl.reads_rs  = 1'b1;
               ctrl.reads_rt  = 1'b1;
               ctrl.alu_op    = (funct == FN_SUB) ? ALU_SUB : ALU_ADD;
            end
         end
         OP_ORI: begin
            ctrl.legal     = 1'b1;
            ctrl.reg_write = 1'b1;
            ctrl.alu_src   = 1'b1;
            ctrl.reads_rs  = 1'b1;
            ctrl.alu_op    = ALU_OR;
         end
         OP_LW: begin
            ctrl.legal      = 1'b1;
            ctrl.reg_write  = 1'b1;
            ctrl.mem_to_reg = 1'b1;
            ctrl.alu_src    = 1'b1;
            ctrl.sign_ext   = 1'b1;
            ctrl.reads_rs   = 1'b1;
         end
         OP_SW: begin
            ctrl.legal     = 1'b1;
            ctrl.mem_write = 1'b1;
            ctrl.alu_src   = 1'b1;
            ctrl.sign_ext  = 1'b1;
            ctrl.reads_rs  = 1'b1;
            ctrl.reads_rt  = 1'b1;
         end
         OP_BEQ: begin
            ctrl.legal    = 1'b1;
            ctrl.branch   = 1'b1;
            ctrl.sign_ext = 1'b1;
            ctrl.reads_rs = 1'b1;
            ctrl.reads_rt = 1'b1;
            ctrl.alu_op   = ALU_SUB;
         end
         OP_J: begin
            ctrl.legal = 1'b1;
            ctrl.jump  = 1'b1;
         end
         default: ctrl.legal = 1'b0;
      endcase
   end
endmodule

// File: rtl/pipe5_alu.sv
`timescale 1ns/1ps
module pipe5_alu
   import pipe5_pkg::*;
#(
   parameter int XLEN = 32
) (
   input  logic [XLEN-1:0] a,
   input  logic [XLEN-1:0] b,
   input  alu_op_e         op,
   output logic [XLEN-1:0] y,
   output logic            zero
);
   always_comb begin
      case (op)
         ALU_SUB: y = a - b;
         ALU_OR:  y = a | b;
         default: y = a + b;
      endcase
   end
   assign zero = (y == '0);
endmodule

// File: rtl/pipe5_regfile.sv
`timescale 1ns/1ps
module pipe5_regfile #(
   parameter int XLEN      = 32,
   parameter int NREG      = 32,
   parameter bit WB_BYPASS = 1'b1,
   localparam int AW       = $clog2(NREG)
) (
   input  logic                clk,
   input  logic                rst,
   input  logic                we,
   input  logic [AW-1:0]       waddr,
   input  logic [XLEN-1:0]     wdata,
   input  logic [1:0][AW-1:0]  raddr,
   output logic [1:0][XLEN-1:0] rdata
);
   logic [XLEN-1:0] regs [NREG];

   always_ff @(posedge clk) begin
      if (we && waddr != '0) regs[waddr] <= wdata;
   end

   for (genvar p = 0; p < 2; p++) begin : g_port
      logic [XLEN-1:0] stored;
      assign stored = (raddr[p] == '0) ? '0 : regs[raddr[p]];
      if (WB_BYPASS) begin : g_share
         assign rdata[p] = (we && waddr != '0 && waddr == raddr[p]) ? wdata : stored;
         // R6
         wb_share_chk: assert property (@(posedge clk) disable iff (rst)
            (we && waddr != '0 && raddr[p] == waddr) |-> rdata[p] == wdata);
      end else begin : g_plain
         assign rdata[p] = stored;
      end
      // R9
      zero_reg_chk: assert property (@(posedge clk) disable iff (rst)
         (raddr[p] == '0) |-> rdata[p] == '0);
   end
endmodule

// File: rtl/pipe5_core.sv
`timescale 1ns/1ps
module pipe5_core
   import pipe5_pkg::*;
#(
   parameter int              XLEN      = 32,
   parameter int              NREG      = 32,
   parameter logic [XLEN-1:0] RESET_PC  = '0,
   parameter bit              WB_BYPASS = 1'b1
) (
   input  logic            clk,
   input  logic            rst,
   output logic [XLEN-1:0] imem_addr,
   input  logic [31:0]     imem_rdata,
   output logic [XLEN-1:0] dmem_addr,
   output logic [XLEN-1:0] dmem_wdata,
   output logic            dmem_we,
   input  logic [XLEN-1:0] dmem_rdata
);
   localparam int AW   = $clog2(NREG);
   localparam int IMMW = 16;
   localparam int JW   = 26;

   if (XLEN != 32) begin : g_bad_xlen
      $error("pipe5_core: XLEN must be 32");
   end
   if (NREG != 32) begin : g_bad_nreg
      $error("pipe5_core: NREG must be 32 to match 5-bit register fields");
   end

   typedef struct packed {
      logic            valid;
      logic [XLEN-1:0] pc4;
      logic [31:0]     instr;
   } ifid_t;

   typedef struct packed {
      logic            valid;
      logic            reg_write, mem_to_reg, mem_write, alu_src, branch, jump;
      alu_op_e         alu_op;
      logic [XLEN-1:0] pc4, a, b, imm;
      logic [AW-1:0]   dest;
      logic [JW-1:0]   jidx;
   } idex_t;

   typedef struct packed {
      logic            valid, reg_write, mem_to_reg, mem_write;
      logic [AW-1:0]   dest;
      logic [XLEN-1:0] alu, sdata;
   } exmem_t;

   typedef struct packed {
      logic            valid, reg_write;
      logic [AW-1:0]   dest;
      logic [XLEN-1:0] wdata;
   } memwb_t;

   function automatic logic hits(input logic v, input logic w,
                                 input logic [AW-1:0] d, input logic [AW-1:0] s);
      return v && w && (d != '0) && (d == s);
   endfunction

   logic [XLEN-1:0] pc_q;
   ifid_t  ifid_q;
   idex_t  idex_q, idex_d;
   exmem_t exmem_q, exmem_d;
   memwb_t memwb_q, memwb_d;
   ctrl_t  dctl;

   // decode stage
   logic [AW-1:0]        rs, rt, rd;
   logic [1:0][XLEN-1:0] rf_rdata;
   logic                 wb_we;

   assign rs    = ifid_q.instr[25:21];
   assign rt    = ifid_q.instr[20:16];
   assign rd    = ifid_q.instr[15:11];
   assign wb_we = memwb_q.valid && memwb_q.reg_write;

   pipe5_decode u_dec (
      .opcode (ifid_q.instr[31:26]),
      .funct  (ifid_q.instr[5:0]),
      .ctrl   (dctl)
   );

   pipe5_regfile #(.XLEN(XLEN), .NREG(NREG), .WB_BYPASS(WB_BYPASS)) u_rf (
      .clk   (clk),
      .rst   (rst),
      .we    (wb_we),
      .waddr (memwb_q.dest),
      .wdata (memwb_q.wdata),
      .raddr ({rt, rs}),
      .rdata (rf_rdata)
   );

   always_comb begin
      idex_d            = '0;
      idex_d.valid      = ifid_q.valid && dctl.legal;
      idex_d.reg_write  = dctl.reg_write;
      idex_d.mem_to_reg = dctl.mem_to_reg;
      idex_d.mem_write  = dctl.mem_write;
      idex_d.alu_src    = dctl.alu_src;
      idex_d.branch     = dctl.branch;
      idex_d.jump       = dctl.jump;
      idex_d.alu_op     = dctl.alu_op;
      idex_d.pc4        = ifid_q.pc4;
      idex_d.a          = rf_rdata[0];
      idex_d.b          = rf_rdata[1];
      idex_d.imm        = dctl.sign_ext
                          ? {{(XLEN-IMMW){ifid_q.instr[IMMW-1]}}, ifid_q.instr[IMMW-1:0]}
                          : {{(XLEN-IMMW){1'b0}}, ifid_q.instr[IMMW-1:0]};
      idex_d.dest       = dctl.reg_dst ? rd : rt;
      idex_d.jidx       = ifid_q.instr[JW-1:0];
   end

   // interlock
   logic [1:0] wb_hit;
   if (WB_BYPASS) begin : g_wb_shared
      assign wb_hit = 2'b00;
   end else begin : g_wb_stall
      assign wb_hit = {hits(memwb_q.valid, memwb_q.reg_write, memwb_q.dest, rt),
                       hits(memwb_q.valid, memwb_q.reg_write, memwb_q.dest, rs)};
   end

   logic rs_busy, rt_busy, stall;
   assign rs_busy = hits(idex_q.valid, idex_q.reg_write, idex_q.dest, rs)
                 || hits(exmem_q.valid, exmem_q.reg_write, exmem_q.dest, rs) || wb_hit[0];
   assign rt_busy = hits(idex_q.valid, idex_q.reg_write, idex_q.dest, rt)
                 || hits(exmem_q.valid, exmem_q.reg_write, exmem_q.dest, rt) || wb_hit[1];
   assign stall   = ifid_q.valid && ((dctl.reads_rs && rs_busy) || (dctl.reads_rt && rt_busy));

   // execute stage
   logic [XLEN-1:0] alu_y, tgt;
   logic            alu_zero, redirect;

   pipe5_alu #(.XLEN(XLEN)) u_alu (
      .a    (idex_q.a),
      .b    (idex_q.alu_src ? idex_q.imm : idex_q.b),
      .op   (idex_q.alu_op),
      .y    (alu_y),
      .zero (alu_zero)
   );

   assign redirect = idex_q.valid && (idex_q.jump || (idex_q.branch && alu_zero));
   assign tgt      = idex_q.jump
                     ? {idex_q.pc4[XLEN-1:XLEN-4], idex_q.jidx, 2'b00}
                     : idex_q.pc4 + {idex_q.imm[XLEN-3:0], 2'b00};

   always_comb begin
      exmem_d            = '0;
      exmem_d.valid      = idex_q.valid;
      exmem_d.reg_write  = idex_q.valid && idex_q.reg_write;
      exmem_d.mem_to_reg = idex_q.mem_to_reg;
      exmem_d.mem_write  = idex_q.valid && idex_q.mem_write;
      exmem_d.dest       = idex_q.dest;
      exmem_d.alu        = alu_y;
      exmem_d.sdata      = idex_q.b;
   end

   // memory stage
   assign dmem_addr  = exmem_q.alu;
   assign dmem_wdata = exmem_q.sdata;
   assign dmem_we    = exmem_q.valid && exmem_q.mem_write;
   assign imem_addr  = pc_q;

   always_comb begin
      memwb_d           = '0;
      memwb_d.valid     = exmem_q.valid;
      memwb_d.reg_write = exmem_q.reg_write;
      memwb_d.dest      = exmem_q.dest;
      memwb_d.wdata     = exmem_q.mem_to_reg ? dmem_rdata : exmem_q.alu;
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         pc_q          <= RESET_PC;
         ifid_q.valid  <= 1'b0;
         idex_q.valid  <= 1'b0;
         exmem_q.valid <= 1'b0;
         memwb_q.valid <= 1'b0;
      end else begin
         memwb_q <= memwb_d;
         exmem_q <= exmem_d;
         if (redirect) begin
            pc_q         <= tgt;
            ifid_q.valid <= 1'b0;
            idex_q.valid <= 1'b0;
         end else if (stall) begin
            idex_q.valid <= 1'b0;
         end else begin
            pc_q         <= pc_q + XLEN'(4);
            ifid_q.valid <= 1'b1;
            ifid_q.pc4   <= pc_q + XLEN'(4);
            ifid_q.instr <= imem_rdata;
            idex_q       <= idex_d;
         end
      end
   end

   // R7
   redirect_squash_chk: assert property (@(posedge clk) disable iff (rst)
      redirect |=> !ifid_q.valid && !idex_q.valid);
   // R4
   stall_hold_chk: assert property (@(posedge clk) disable iff (rst)
      (stall && !redirect) |=> $stable(pc_q) && !idex_q.valid);
   // R2
   ctrl_excl_chk: assert property (@(posedge clk) disable iff (rst)
      ifid_q.valid |-> $onehot0({dctl.reg_write, dctl.mem_write, dctl.branch, dctl.jump}));
   // R10
   store_origin_chk: assert property (@(posedge clk) disable iff (rst)
      dmem_we |-> $past(idex_q.valid) && $past(idex_q.mem_write));
endmodule

// File: tb/pipe5_core_tb.sv
`timescale 1ns/1ps
module pipe5_core_tb;
   logic        clk = 1'b0;
   logic        rst = 1'b1;
   logic [31:0] imem_addr, imem_rdata, dmem_addr, dmem_wdata, dmem_rdata;
   logic        dmem_we;

   logic [31:0] prog [64];
   string       stag [64];
   logic [31:0] dmem [64];
   logic [31:0] mdl_mem [64];

   logic [31:0] exp_addr [$];
   logic [31:0] exp_data [$];
   string       exp_tag  [$];

   int n_tests = 0;
   int n_fail  = 0;

   always #2.5 clk = ~clk;

   pipe5_core u_dut (
      .clk        (clk),
      .rst        (rst),
      .imem_addr  (imem_addr),
      .imem_rdata (imem_rdata),
      .dmem_addr  (dmem_addr),
      .dmem_wdata (dmem_wdata),
      .dmem_we    (dmem_we),
      .dmem_rdata (dmem_rdata)
   );

   assign imem_rdata = prog[imem_addr[7:2]];
   assign dmem_rdata = dmem[dmem_addr[7:2]];

   always @(posedge clk) if (dmem_we) dmem[dmem_addr[7:2]] <= dmem_wdata;

   function automatic logic [31:0] enc_r(input int s, input int t, input int d, input logic [5:0] fn);
      return {6'b000000, 5'(s), 5'(t), 5'(d), 5'd0, fn};
   endfunction
   function automatic logic [31:0] enc_i(input logic [5:0] op, input int s, input int t, input logic [15:0] imm);
      return {op, 5'(s), 5'(t), imm};
   endfunction
   function automatic logic [31:0] enc_j(input int idx);
      return {6'b000010, 26'(idx)};
   endfunction

   localparam logic [5:0] ADD = 6'b100000, SUB = 6'b100010;
   localparam logic [5:0] ORI = 6'b001101, LW = 6'b100011, SW = 6'b101011, BEQ = 6'b000100;

   task automatic build_prog();
      for (int i = 0; i < 64; i++) begin prog[i] = 32'hFFFF_FFFF; stag[i] = "--"; dmem[i] = '0; mdl_mem[i] = '0; end
      prog[0]  = enc_i(ORI, 0, 1, 16'd5);
      prog[1]  = enc_i(ORI, 0, 2, 16'd3);
      prog[2]  = enc_r(1, 2, 3, ADD);            // back-to-back dependency
      prog[3]  = enc_r(3, 1, 4, SUB);
      prog[4]  = enc_i(SW, 0, 3, 16'd0);   stag[4]  = "R4";
      prog[5]  = enc_i(SW, 0, 4, 16'd4);   stag[5]  = "R2";
      prog[6]  = enc_i(LW, 0, 5, 16'd0);
      prog[7]  = enc_r(5, 5, 6, ADD);            // load then immediate use
      prog[8]  = enc_i(SW, 0, 6, 16'd8);   stag[8]  = "R5";
      prog[9]  = enc_i(BEQ, 1, 2, 16'd2);        // falls through
      prog[10] = enc_i(ORI, 0, 7, 16'h00AA);
      prog[11] = enc_i(BEQ, 1, 1, 16'd2);        // taken to 14
      prog[12] = enc_i(ORI, 0, 7, 16'h0BAD);
      prog[13] = enc_i(ORI, 0, 7, 16'h0BAD);
      prog[14] = enc_i(SW, 0, 7, 16'd12);  stag[14] = "R7";
      prog[15] = enc_j(18);
      prog[16] = enc_i(ORI, 0, 7, 16'h0111);
      prog[17] = enc_i(SW, 0, 7, 16'd60);  stag[17] = "R8";
      prog[18] = enc_r(1, 1, 0, ADD);            // write to register 0
      prog[19] = enc_i(SW, 0, 0, 16'd16);  stag[19] = "R9";
      prog[20] = enc_r(0, 1, 9, SUB);
      prog[21] = enc_i(SW, 0, 9, 16'd20);  stag[21] = "R2";
      prog[22] = enc_i(ORI, 0, 11, 16'h8000);
      prog[23] = enc_i(SW, 0, 11, 16'd24); stag[23] = "R3";
      prog[24] = enc_i(ORI, 0, 13, 16'd32);
      prog[25] = enc_i(LW, 13, 12, 16'hFFF8);    // negative offset
      prog[26] = enc_i(SW, 0, 12, 16'd28); stag[26] = "R3";
      prog[27] = enc_i(ORI, 0, 15, 16'd7);
      prog[28] = enc_i(ORI, 0, 16, 16'd1);
      prog[29] = enc_i(ORI, 0, 17, 16'd2);
      prog[30] = enc_r(15, 0, 18, ADD);          // producer in write-back
      prog[31] = enc_i(SW, 0, 18, 16'd32); stag[31] = "R6";
      prog[32] = enc_i(SW, 0, 7, 16'd36);  stag[32] = "R8";
      prog[33] = enc_j(33);
   endtask

   // instruction-level model: predicts each store (driver side of the scoreboard)
   task automatic run_model();
      logic [31:0] r [32];
      logic [31:0] pc, npc, ins, simm, zimm, ea, jt;
      bit          done;
      for (int i = 0; i < 32; i++) r[i] = '0;
      pc   = '0;
      done = 1'b0;
      for (int s = 0; s < 400 && !done; s++) begin
         ins  = prog[pc[7:2]];
         simm = {{16{ins[15]}}, ins[15:0]};
         zimm = {16'd0, ins[15:0]};
         npc  = pc + 4;
         ea   = r[ins[25:21]] + simm;
         case (ins[31:26])
            6'b000000: begin
               if (ins[5:0] == ADD) r[ins[15:11]] = r[ins[25:21]] + r[ins[20:16]];
               else if (ins[5:0] == SUB) r[ins[15:11]] = r[ins[25:21]] - r[ins[20:16]];
            end
            ORI: r[ins[20:16]] = r[ins[25:21]] | zimm;
            LW:  r[ins[20:16]] = mdl_mem[ea[7:2]];
            SW: begin
               mdl_mem[ea[7:2]] = r[ins[20:16]];
               exp_addr.push_back(ea);
               exp_data.push_back(r[ins[20:16]]);
               exp_tag.push_back(stag[pc[7:2]]);
            end
            BEQ: if (r[ins[25:21]] == r[ins[20:16]]) npc = pc + 4 + {simm[29:0], 2'b00};
            6'b000010: begin
               jt = {npc[31:28], ins[25:0], 2'b00};
               if (jt == pc) done = 1'b1;
               npc = jt;
            end
            default: ;
         endcase
         r[0] = '0;
         pc   = npc;
      end
   endtask

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp, input string what);
      n_tests++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
      end
   endtask

   // monitor: pop and compare each store as it leaves the core (R10 ordering)
   always @(negedge clk) begin
      if (!rst && dmem_we) begin
         if (exp_addr.size() == 0) begin
            check("R10", dmem_addr, 32'hXXXX_XXXX, "unexpected store");
         end else begin
            check(exp_tag[0], dmem_addr, exp_addr[0], "store address");
            check(exp_tag[0], dmem_wdata, exp_data[0], "store data");
            void'(exp_addr.pop_front());
            void'(exp_data.pop_front());
            void'(exp_tag.pop_front());
         end
      end
   end

   initial begin
      int cyc;
      build_prog();
      run_model();
      repeat (3) @(posedge clk);
      @(negedge clk);
      // R1 reset state
      check("R1", imem_addr, 32'h0, "fetch address in reset");
      check("R1", {31'd0, dmem_we}, 32'h0, "store strobe in reset");
      rst = 1'b0;
      cyc = 0;
      while (exp_addr.size() != 0 && cyc < 5000) begin
         @(negedge clk);
         cyc++;
      end
      if (cyc >= 5000) begin
         n_tests++;
         n_fail++;
         $display("FAIL R10 watchdog: actual %0d pending stores expected 0", exp_addr.size());
      end
      repeat (20) @(negedge clk);
      // R10 final memory image
      for (int i = 0; i < 16; i++) check("R10", dmem[i], mdl_mem[i], "final memory word");
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end
endmodule